// File: doc/BRIEF.md
# Clustered Shared-Cache Coherence Controller

This block sits between a group of cores and one main store. Cores are grouped into clusters, and every cluster owns one shared cache slice. Each slice is direct-mapped. Every entry in a slice holds a tag, a value and a clean/dirty flag.

A core write lands only in its cluster's slice and marks the entry dirty. The write is then propagated in the background. The controller first pushes the new value over the inter-slice bus into every other slice that holds the same address, and those copies become clean. Only after that does it write the store and clean the source entry. Other copies are updated, never invalidated.

Cores that share a slice see each other's writes at once, at no cost. A read miss fetches from the store over a fixed latency. Write-write races on one address from different clusters are a program error: the value pushed last overwrites the other.

Top module: `coh_cluster_cache`

## Requirements
- R1: After reset no core response is pending, the store port neither reads nor writes, and every slice entry is empty, so the first read of any address misses.
- R2: A read that hits in the core's own slice returns the cached value with its response one cycle after the request is presented.
- R3: A read miss reads the store for STORE_LAT cycles, keeping the address steady. The response comes STORE_LAT+1 cycles after the request. The line is allocated clean when the indexed entry is empty or clean, so a repeat read hits.
- R4: A read miss whose indexed entry is dirty with another tag bypasses the slice. It returns the store value, the dirty entry stays and still hits, and a repeat read of the missed address misses again.
- R5: A write updates only its cluster's slice, marks the entry dirty and answers in one cycle. The store still holds the old value when that response is seen.
- R6: Cores in the same cluster share one slice, so a read by one core right after a write by another returns the new value as a hit.
- R7: When the controller is idle, a dirty value is pushed into every other slice holding that address, and those copies stay present as clean. A later read there hits and returns the new value.
- R8: The store is written with a dirty value only while every slice holding that address holds that same value and at most one holder is dirty. Once the controller has drained, the store equals the last value written to every address.
- R9: A write whose indexed entry is dirty with another tag stalls until that entry has been written to the store and cleaned, and only then completes. Only clean entries are ever replaced.
- R10: Requests presented by several cores at once are granted in rotating order. Each request gets exactly one response, and no two responses occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | N_CORE | Per-core request, held until that core's response |
| core_we | input | N_CORE | Per-core write (1) or read (0) |
| core_addr | input | N_CORE*AW | Per-core address, core k in bits [k*AW +: AW]; low log2(ENTRIES) bits index the slice |
| core_wdata | input | N_CORE*DW | Per-core write data, core k in bits [k*DW +: DW] |
| core_rsp | output | N_CORE | One-cycle response pulse for the served core |
| core_rdata | output | DW | Read data, valid with core_rsp |
| mem_re | output | 1 | Store read, held STORE_LAT cycles |
| mem_we | output | 1 | Store write, held STORE_LAT cycles |
| mem_addr | output | AW | Store address |
| mem_wdata | output | DW | Store write data |
| mem_rdata | input | DW | Store read data, sampled in the last read cycle |

## Verification
The hardest situation to reach is a slice that holds a dirty line at the moment a conflicting access arrives. Background propagation starts as soon as no request is pending, so it cleans the line unless the next request follows immediately. The bench therefore chains the dirty-victim read bypass, the stalled write and the same-cluster sharing cases with no idle cycle between responses and new requests. It waits for drain only before cross-cluster checks, where it then expects the pushed value to hit in the remote slice. The random phase chains runs of same-cluster operations back to back and drains whenever the cluster changes.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FILL  = 2'd1,
        PH_PUSH  = 2'd2,
        PH_STORE = 2'd3
    } phase_e;
endpackage

// File: rtl/coh_rr_pick.sv
module coh_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          any,
    output logic [IW-1:0] pick
);
    int idx;
    always_comb begin
        any  = 1'b0;
        pick = '0;
        idx  = 0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!any && req[idx]) begin
                any  = 1'b1;
                pick = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/coh_holders.sv
module coh_holders #(
    parameter int N_CL    = 2,
    parameter int ENTRIES = 4,
    parameter int TW      = 4,
    parameter int IXW     = 2
) (
    input  logic [N_CL-1:0][ENTRIES-1:0]         vld,
    input  logic [N_CL-1:0][ENTRIES-1:0][TW-1:0] tag,
    input  logic [IXW-1:0]                       ix,
    input  logic [TW-1:0]                        tg,
    output logic [N_CL-1:0]                      hold
);
    for (genvar s = 0; s < N_CL; s++) begin : g_slice
        assign hold[s] = vld[s][ix] && (tag[s][ix] == tg);
    end
endmodule

// File: rtl/coh_cluster_cache.sv
module coh_cluster_cache
    import coh_pkg::*;
#(
    parameter int N_CORE    = 4,
    parameter int CL_CORES  = 2,
    parameter int ENTRIES   = 4,
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int STORE_LAT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CORE-1:0]    core_req,
    input  logic [N_CORE-1:0]    core_we,
    input  logic [N_CORE*AW-1:0] core_addr,
    input  logic [N_CORE*DW-1:0] core_wdata,
    output logic [N_CORE-1:0]    core_rsp,
    output logic [DW-1:0]        core_rdata,
    output logic                 mem_re,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata
);
    localparam int N_CL = N_CORE / CL_CORES;
    localparam int IXW  = $clog2(ENTRIES);
    localparam int TW   = AW - IXW;
    localparam int CW   = (N_CORE > 1) ? $clog2(N_CORE) : 1;
    localparam int SW   = (N_CL > 1) ? $clog2(N_CL) : 1;
    localparam int LW   = $clog2(STORE_LAT + 1);

    typedef struct packed {
        phase_e                               ph;
        logic [LW-1:0]                        cnt;
        logic [CW-1:0]                        cur;
        logic [AW-1:0]                        raddr;
        logic [CW-1:0]                        cptr;
        logic [SW-1:0]                        sptr;
        logic [SW-1:0]                        fsl;
        logic [IXW-1:0]                       fix;
        logic [N_CORE-1:0]                    rsp;
        logic [DW-1:0]                        rdata;
        logic [N_CL-1:0][ENTRIES-1:0]         vld;
        logic [N_CL-1:0][ENTRIES-1:0]         drt;
        logic [N_CL-1:0][ENTRIES-1:0][TW-1:0] tag;
        logic [N_CL-1:0][ENTRIES-1:0][DW-1:0] dat;
    } state_t;

    state_t q, d;

    // request selection and lookup
    logic            g_any;
    logic [CW-1:0]   g;
    logic [AW-1:0]   r_addr;
    logic [DW-1:0]   r_wd;
    logic            r_we;
    logic [SW-1:0]   r_cl;
    logic [N_CL-1:0] r_hold;

    coh_rr_pick #(.N(N_CORE), .IW(CW)) u_core_pick (
        .req(core_req), .ptr(q.cptr), .any(g_any), .pick(g)
    );

    always_comb begin
        r_addr = core_addr[int'(g)*AW +: AW];
        r_wd   = core_wdata[int'(g)*DW +: DW];
        r_we   = core_we[g];
        r_cl   = SW'(int'(g) / CL_CORES);
    end

    coh_holders #(.N_CL(N_CL), .ENTRIES(ENTRIES), .TW(TW), .IXW(IXW)) u_req_hold (
        .vld(q.vld), .tag(q.tag), .ix(r_addr[IXW-1:0]), .tg(r_addr[AW-1:IXW]), .hold(r_hold)
    );

    // background dirty-line selection
    logic [N_CL-1:0] sl_dirty;
    logic            f_any;
    logic [SW-1:0]   f_sl;
    logic [IXW-1:0]  f_ix;

    for (genvar s = 0; s < N_CL; s++) begin : g_sd
        assign sl_dirty[s] = |q.drt[s];
    end

    coh_rr_pick #(.N(N_CL), .IW(SW)) u_slice_pick (
        .req(sl_dirty), .ptr(q.sptr), .any(f_any), .pick(f_sl)
    );

    always_comb begin
        f_ix = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (q.drt[f_sl][e]) f_ix = IXW'(e);
        end
    end

    // propagation target and its other holders
    logic            vic_dirty;
    logic [SW-1:0]   t_sl;
    logic [IXW-1:0]  t_ix;
    logic [N_CL-1:0] t_hold;
    logic            stale;

    always_comb begin
        vic_dirty = !r_hold[r_cl] && q.vld[r_cl][r_addr[IXW-1:0]]
                    && q.drt[r_cl][r_addr[IXW-1:0]];
        if (q.ph != PH_IDLE) begin
            t_sl = q.fsl;
            t_ix = q.fix;
        end else if (g_any && r_we && vic_dirty) begin
            t_sl = r_cl;
            t_ix = r_addr[IXW-1:0];
        end else begin
            t_sl = f_sl;
            t_ix = f_ix;
        end
    end

    coh_holders #(.N_CL(N_CL), .ENTRIES(ENTRIES), .TW(TW), .IXW(IXW)) u_tgt_hold (
        .vld(q.vld), .tag(q.tag), .ix(t_ix), .tg(q.tag[t_sl][t_ix]), .hold(t_hold)
    );

    always_comb begin
        stale = 1'b0;
        for (int s = 0; s < N_CL; s++) begin
            if (SW'(s) != t_sl && t_hold[s]
                && (q.drt[s][t_ix] || q.dat[s][t_ix] != q.dat[t_sl][t_ix]))
                stale = 1'b1;
        end
    end

    // next-state logic
    logic [SW-1:0]  fcl;
    logic [IXW-1:0] fix2;

    always_comb begin
        d     = q;
        d.rsp = '0;
        fcl   = SW'(int'(q.cur) / CL_CORES);
        fix2  = q.raddr[IXW-1:0];
        unique case (q.ph)
            PH_IDLE: begin
                if (g_any && !r_we) begin
                    d.cptr = CW'((int'(g) + 1) % N_CORE);
                    if (r_hold[r_cl]) begin
                        d.rsp[g] = 1'b1;
                        d.rdata  = q.dat[r_cl][r_addr[IXW-1:0]];
                    end else begin
                        d.ph    = PH_FILL;
                        d.cnt   = LW'(STORE_LAT - 1);
                        d.cur   = g;
                        d.raddr = r_addr;
                    end
                end else if (g_any && !vic_dirty) begin
                    d.vld[r_cl][r_addr[IXW-1:0]] = 1'b1;
                    d.drt[r_cl][r_addr[IXW-1:0]] = 1'b1;
                    d.tag[r_cl][r_addr[IXW-1:0]] = r_addr[AW-1:IXW];
                    d.dat[r_cl][r_addr[IXW-1:0]] = r_wd;
                    d.rsp[g] = 1'b1;
                    d.cptr   = CW'((int'(g) + 1) % N_CORE);
                end else if (g_any || f_any) begin
                    if (!g_any) d.sptr = SW'((int'(f_sl) + 1) % N_CL);
                    d.fsl = t_sl;
                    d.fix = t_ix;
                    d.cnt = LW'(STORE_LAT - 1);
                    d.ph  = stale ? PH_PUSH : PH_STORE;
                end
            end
            PH_FILL: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.ph        = PH_IDLE;
                    d.rsp[q.cur] = 1'b1;
                    d.rdata     = mem_rdata;
                    if (!(q.vld[fcl][fix2] && q.drt[fcl][fix2])) begin
                        d.vld[fcl][fix2] = 1'b1;
                        d.drt[fcl][fix2] = 1'b0;
                        d.tag[fcl][fix2] = q.raddr[AW-1:IXW];
                        d.dat[fcl][fix2] = mem_rdata;
                    end
                end
            end
            PH_PUSH: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    for (int s = 0; s < N_CL; s++) begin
                        if (SW'(s) != q.fsl && t_hold[s]) begin
                            d.dat[s][q.fix] = q.dat[q.fsl][q.fix];
                            d.drt[s][q.fix] = 1'b0;
                        end
                    end
                    d.ph  = PH_STORE;
                    d.cnt = LW'(STORE_LAT - 1);
                end
            end
            PH_STORE: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.drt[q.fsl][q.fix] = 1'b0;
                    d.ph = PH_IDLE;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign core_rsp   = q.rsp;
    assign core_rdata = q.rdata;
    assign mem_re     = (q.ph == PH_FILL);
    assign mem_we     = (q.ph == PH_STORE);
    assign mem_addr   = (q.ph == PH_FILL) ? q.raddr : {q.tag[q.fsl][q.fix], q.fix};
    assign mem_wdata  = q.dat[q.fsl][q.fix];
endmodule

// File: rtl/coh_cluster_cache_chk.sv
module coh_cluster_cache_chk #(
    parameter int N_CORE    = 4,
    parameter int CL_CORES  = 2,
    parameter int ENTRIES   = 4,
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int STORE_LAT = 4
) (
    input logic                                                    clk,
    input logic                                                    rst_n,
    input logic [N_CORE-1:0]                                       core_rsp,
    input logic                                                    mem_re,
    input logic                                                    mem_we,
    input logic [AW-1:0]                                           mem_addr,
    input logic [DW-1:0]                                           mem_wdata,
    input logic [N_CORE/CL_CORES-1:0][ENTRIES-1:0]                 vld,
    input logic [N_CORE/CL_CORES-1:0][ENTRIES-1:0]                 drt,
    input logic [N_CORE/CL_CORES-1:0][ENTRIES-1:0][AW-$clog2(ENTRIES)-1:0] tag,
    input logic [N_CORE/CL_CORES-1:0][ENTRIES-1:0][DW-1:0]         dat
);
    localparam int N_CL = N_CORE / CL_CORES;
    localparam int IXW  = $clog2(ENTRIES);

    logic agree;
    int   ndirty;

    always_comb begin
        agree  = 1'b1;
        ndirty = 0;
        for (int s = 0; s < N_CL; s++) begin
            if (vld[s][mem_addr[IXW-1:0]] && tag[s][mem_addr[IXW-1:0]] == mem_addr[AW-1:IXW]) begin
                if (dat[s][mem_addr[IXW-1:0]] != mem_wdata) agree = 1'b0;
                if (drt[s][mem_addr[IXW-1:0]]) ndirty++;
            end
        end
        if (ndirty > 1) agree = 1'b0;
    end

    a_r10_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_rsp));

    a_r8_store_agree: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> agree);

    a_r3_fill_steady: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_re) |=> (mem_re && $stable(mem_addr)));

    a_r1_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    a_r5_dirty_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (drt & ~vld) == '0);
endmodule

bind coh_cluster_cache coh_cluster_cache_chk #(
    .N_CORE(N_CORE), .CL_CORES(CL_CORES), .ENTRIES(ENTRIES),
    .AW(AW), .DW(DW), .STORE_LAT(STORE_LAT)
) i_chk (
    .clk(clk), .rst_n(rst_n), .core_rsp(core_rsp), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .vld(q.vld), .drt(q.drt), .tag(q.tag), .dat(q.dat)
);

// File: tb/test_coh_cluster_cache.sv
`timescale 1ns/1ps
module test_coh_cluster_cache;
    localparam int NC = 4;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int NA = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     core_req = '0;
    logic [NC-1:0]     core_we = '0;
    logic [NC*AW-1:0]  core_addr = '0;
    logic [NC*DW-1:0]  core_wdata = '0;
    logic [NC-1:0]     core_rsp;
    logic [DW-1:0]     core_rdata;
    logic              mem_re, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_wdata;
    logic [DW-1:0]     mem_rdata;

    logic [DW-1:0] smem [NA];
    logic [DW-1:0] expm [NA];
    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    assign mem_rdata = smem[mem_addr];
    always @(posedge clk) if (mem_we) smem[mem_addr] <= mem_wdata;

    coh_cluster_cache i_coh_cluster_cache (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_rsp(core_rsp),
        .core_rdata(core_rdata), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'(a * 5 + 1);
    endfunction

    task automatic chk(input bit ok, input string tg, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tg, act, exp);
        end
    endtask

    task automatic drain(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called just after a falling edge; returns at the falling edge where the response is seen
    task automatic op(input int c, input bit w, input int a, input logic [DW-1:0] wd,
                      output logic [DW-1:0] rd, output int lat);
        core_req[c] = 1'b1;
        core_we[c] = w;
        core_addr[c*AW +: AW] = AW'(a);
        core_wdata[c*DW +: DW] = wd;
        lat = 0;
        rd = '0;
        while (1) begin
            @(negedge clk);
            lat++;
            if (core_rsp[c]) break;
            if (lat > 300) begin
                chk(0, "op timeout", lat, 0);
                break;
            end
        end
        rd = core_rdata;
        core_req[c] = 1'b0;
        if (w) expm[a] = wd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int lat;
        int prev_cl;
        for (int a = 0; a < NA; a++) begin
            smem[a] = init_val(a);
            expm[a] = init_val(a);
        end
        repeat (3) @(negedge clk);
        chk(core_rsp == '0, "R1 rsp idle in reset", int'(core_rsp), 0);
        chk(!mem_re && !mem_we, "R1 store port idle", int'({mem_re, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(core_rsp == '0 && !mem_re && !mem_we, "R1 idle after reset", int'(core_rsp), 0);

        // R1/R3 cold miss then hit
        op(2, 0, 9, 0, rd, lat);
        chk(lat == 5, "R1 R3 cold miss latency", lat, 5);
        chk(rd == expm[9], "R3 miss data", rd, expm[9]);
        op(3, 0, 9, 0, rd, lat);
        chk(lat == 1, "R2 R3 allocated line hits", lat, 1);
        chk(rd == expm[9], "R2 hit data", rd, expm[9]);

        // R5 write stays in slice, R6 shared slice
        op(0, 1, 1, 8'hA5, rd, lat);
        chk(lat == 1, "R5 write latency", lat, 1);
        chk(smem[1] == init_val(1), "R5 store untouched at write response", smem[1], init_val(1));
        op(1, 0, 1, 0, rd, lat);
        chk(lat == 1 && rd == 8'hA5, "R6 sibling core hits new value", rd, 8'hA5);
        drain(40);
        chk(smem[1] == 8'hA5, "R8 store updated after drain", smem[1], 8'hA5);

        // R7 update pushed into the other slice
        op(2, 0, 2, 0, rd, lat);
        chk(lat == 5, "R7 remote allocate miss", lat, 5);
        op(0, 1, 2, 8'h3C, rd, lat);
        drain(40);
        op(3, 0, 2, 0, rd, lat);
        chk(lat == 1, "R7 remote copy still present", lat, 1);
        chk(rd == 8'h3C, "R7 remote copy updated", rd, 8'h3C);
        chk(smem[2] == 8'h3C, "R8 store after push", smem[2], 8'h3C);

        // R4 read miss with dirty victim bypasses
        op(0, 1, 3, 8'h11, rd, lat);
        op(0, 0, 7, 0, rd, lat);
        chk(lat == 5 && rd == expm[7], "R4 bypass read data", rd, expm[7]);
        op(1, 0, 3, 0, rd, lat);
        chk(lat == 1 && rd == 8'h11, "R4 dirty victim kept", rd, 8'h11);
        op(1, 0, 7, 0, rd, lat);
        chk(lat == 5, "R4 bypassed line not allocated", lat, 5);
        drain(40);

        // R9 write over dirty victim stalls until victim cleaned
        op(2, 1, 5, 8'h5A, rd, lat);
        op(3, 1, 9, 8'h77, rd, lat);
        chk(lat > 1, "R9 conflicting write stalls", lat, 6);
        chk(smem[5] == 8'h5A, "R9 victim in store before write completes", smem[5], 8'h5A);
        drain(40);
        op(2, 0, 5, 0, rd, lat);
        chk(lat == 5 && rd == 8'h5A, "R9 victim evicted clean", lat, 5);
        op(3, 0, 9, 0, rd, lat);
        chk(rd == 8'h77, "R9 stalled write data", rd, 8'h77);
        drain(40);

        // R10 simultaneous requests
        begin
            logic [NC-1:0] got = '0;
            logic [DW-1:0] gd [NC];
            for (int c = 0; c < NC; c++) begin
                core_req[c] = 1'b1;
                core_we[c] = 1'b0;
                core_addr[c*AW +: AW] = AW'(32 + c);
                gd[c] = '0;
            end
            for (int t = 0; t < 100 && got != '1; t++) begin
                @(negedge clk);
                chk($countones(core_rsp) <= 1, "R10 one response per cycle", $countones(core_rsp), 1);
                for (int c = 0; c < NC; c++) begin
                    if (core_rsp[c]) begin
                        chk(!got[c], "R10 single response per request", c, -1);
                        got[c] = 1'b1;
                        gd[c] = core_rdata;
                        core_req[c] = 1'b0;
                    end
                end
            end
            for (int c = 0; c < NC; c++)
                chk(got[c] && gd[c] == expm[32 + c], "R10 concurrent read served", gd[c], expm[32 + c]);
        end

        // random phase
        void'($urandom(32'd4711));
        prev_cl = 0;
        for (int i = 0; i < 150; i++) begin
            int c;
            int a;
            bit w;
            logic [DW-1:0] wd;
            c = int'($urandom % NC);
            a = int'($urandom % 16);
            w = 1'($urandom % 2);
            wd = DW'($urandom);
            if (c / 2 != prev_cl) drain(30);
            prev_cl = c / 2;
            op(c, w, a, wd, rd, lat);
            if (!w) chk(rd == expm[a], "R2 R3 R6 random read", rd, expm[a]);
        end
        drain(80);
        for (int a = 0; a < NA; a++)
            chk(smem[a] == expm[a], "R8 store matches after drain", smem[a], expm[a]);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule